// File: doc/BRIEF.md
# Descriptor Ring Walker

This block is a bus-master sequencer that works through a circular ring of buffer descriptors held in host memory. Each entry carries a status word with an ownership flag, a buffer address, a buffer length and a message count. The walker reads an entry. When the controller side owns it, the walker hands the buffer address, length and status flags to a downstream consumer. When the consumer reports completion, the walker writes the count and the new status back and returns ownership to the host. It then moves on to the next entry in ring order.

Software sets the ring base address, the ring length, a high-address byte and a descriptor style, then pulses `start`. Two layouts are supported. The compact layout has an 8-byte entry, and the top address byte of every access comes from `cfg_hi`. The wide layout has a 16-byte entry and full 32-bit addresses, in two word orders. One of those orders places the words that are read, and the words that are written back, at ascending adjacent offsets so that each pair can be moved as a burst. All accesses are whole 32-bit words. If the walker reaches an entry that the host owns, it stops there. It re-reads only that entry's status word, once for each `poll` pulse, and never reads ahead.

Top module: `drw_desc_walker`

## Requirements
- R1: After reset, `mem_req` and `dsc_valid` are 0. A `start` pulse in idle sets the index to 0, and the first access is then a read of entry 0's status word.
- R2: `cfg_style` is decoded as follows: 0 is compact (stride 8 bytes, base bits 2:0 ignored); 1 is wide; 2 and 3 are wide burst-ordered (stride 16 bytes, base bits 3:0 ignored). A word address is the aligned base plus index times stride plus the word offset.
- R3: In the compact style, bits 31:24 of every memory address equal `cfg_hi`, and the presented buffer address is {`cfg_hi`, status[23:0]}.
- R4: Word layouts. Compact: status word at +0 {31 owner, 30:24 flags, 23:0 buffer address}, length word at +4 {31:16 count, 15:0 length}. Wide: buffer address at +0, status at +4 {31 owner, 30:16 flags, 15:0 length}, count at +8 bits 15:0. Burst-ordered: count at +0, status at +4, buffer address at +8. The status word is read first, then the other read word.
- R5: If the status word read has bit 31 = 0, the walker issues no further read, makes no offer and performs no write. It stays at that entry and re-reads the same status word once per `poll` pulse, until bit 31 reads 1.
- R6: An owned entry is offered on `dsc_valid` with `dsc_addr`, `dsc_len` and `dsc_flags`, held stable until `dsc_ready`.
- R7: After `cmp_valid`, exactly two writes follow: first the count word, then the status word with bit 31 = 0 and the flags from `cmp_flags` (compact: {0, cmp_flags[6:0], address[23:0]}; wide: {0, cmp_flags, length}). The compact count word is {count, original length}; the wide count word is {16'h0, count}.
- R8: The index advances after the status write and wraps from length−1 to 0. A length of 0 acts as 65536.
- R9: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_gnt`. Read data is taken in the grant cycle.
- R10: Every memory address has bits 1:0 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_style | input | 2 | Descriptor style select |
| cfg_base | input | 32 | Ring base address |
| cfg_hi | input | 8 | High address byte for the compact style |
| cfg_len | input | 16 | Ring length in entries |
| start | input | 1 | Begin walking at entry 0 (idle only) |
| poll | input | 1 | Re-read the status word of a stalled entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| dsc_valid | output | 1 | Owned entry offered |
| dsc_ready | input | 1 | Consumer takes the offer |
| dsc_addr | output | 32 | Buffer address |
| dsc_len | output | 16 | Buffer length |
| dsc_flags | output | 15 | Status flags from the entry |
| cmp_valid | input | 1 | Consumer finished the buffer |
| cmp_flags | input | 15 | Status flags to write back |
| cmp_count | input | 16 | Message count to write back |

## Verification
The walk is tried in all four style codes with deliberately unaligned bases, random high bytes and random field contents, so that a wrong stride, mask, word offset or field slice in any one layout shows up as a wrong address or value. Rings of one, two and three entries are driven past their end. The first entry is left host-owned on the way back round, which separates correct wrapping from running on and tests the stall: no read-ahead while waiting, exactly one status re-read per poll, and progress only once ownership reads as set. A random grant delay on every access, together with random consumer delays, shows that requests and offers hold steady and that the count write always comes before the status write. A very long ring confirms that large lengths walk in order.

// File: rtl/drw_pkg.sv
package drw_pkg;
  localparam int WORD_W  = 32;
  localparam int FLD_W   = 16;
  localparam int FLG_W   = 15;
  localparam int CFLG_W  = 7;
  localparam int OWN_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_STAT, ST_HOLD, ST_RD_AUX,
    ST_OFFER, ST_BUSY, ST_WR_AUX, ST_WR_STAT
  } walk_st_e;

  typedef enum logic [1:0] {ACC_STAT, ACC_AUX_RD, ACC_AUX_WR} acc_sel_e;

  // byte offset of a word inside one entry, per style
  function automatic logic [3:0] word_off(input logic [1:0] style, input acc_sel_e sel);
    logic [3:0] o;
    if (style == 2'd0) begin
      o = (sel == ACC_STAT) ? 4'd0 : 4'd4;
    end else if (style == 2'd1) begin
      o = (sel == ACC_STAT) ? 4'd4 : ((sel == ACC_AUX_RD) ? 4'd0 : 4'd8);
    end else begin
      o = (sel == ACC_STAT) ? 4'd4 : ((sel == ACC_AUX_RD) ? 4'd8 : 4'd0);
    end
    return o;
  endfunction
endpackage

// File: rtl/drw_ring_idx.sv
module drw_ring_idx #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [IDX_W-1:0] len,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             at_end;

  assign at_end = (idx_q == len - ONE);

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (adv) idx_d = at_end ? '0 : idx_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (clr || adv) idx_q <= idx_d;
  end

  assign idx = idx_q;

  // R8
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && idx == len - ONE) |=> idx == '0);

  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && idx != len - ONE) |=> idx == $past(idx) + ONE);
endmodule

// File: rtl/drw_addr_gen.sv
module drw_addr_gen #(
  parameter int AW    = 32,
  parameter int IDX_W = 16,
  parameter int HI_W  = 8
) (
  input  logic [1:0]       style,
  input  logic [AW-1:0]    base,
  input  logic [HI_W-1:0]  hi,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       off,
  output logic [AW-1:0]    addr
);
  localparam int LO_W = AW - HI_W;

  logic            compact;
  logic [AW-1:0]   base_al, step, sum;

  assign compact = (style == 2'd0);

  always_comb begin
    if (compact) begin
      base_al = {base[AW-1:3], 3'b000};
      step    = AW'(idx) << 3;
    end else begin
      base_al = {base[AW-1:4], 4'b0000};
      step    = AW'(idx) << 4;
    end
    sum  = base_al + step + AW'(off);
    addr = compact ? {hi, sum[LO_W-1:0]} : sum;
  end
endmodule

// File: rtl/drw_desc_walker.sv
module drw_desc_walker
  import drw_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int HI_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_style,
  input  logic [WORD_W-1:0] cfg_base,
  input  logic [HI_W-1:0]   cfg_hi,
  input  logic [IDX_W-1:0]  cfg_len,
  input  logic              start,
  input  logic              poll,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              dsc_valid,
  input  logic              dsc_ready,
  output logic [WORD_W-1:0] dsc_addr,
  output logic [FLD_W-1:0]  dsc_len,
  output logic [FLG_W-1:0]  dsc_flags,
  input  logic              cmp_valid,
  input  logic [FLG_W-1:0]  cmp_flags,
  input  logic [FLD_W-1:0]  cmp_count
);
  localparam int LO_W = WORD_W - HI_W;

  walk_st_e          st_q, st_d;
  logic [WORD_W-1:0] stat_q, aux_q;
  logic [FLG_W-1:0]  cflg_q;
  logic [FLD_W-1:0]  ccnt_q;
  logic              cap_stat, cap_aux, cap_cmp, adv, clr;
  logic              compact;
  logic [IDX_W-1:0]  idx;
  acc_sel_e          sel;
  logic [WORD_W-1:0] aux_wr, stat_wr;

  assign compact = (cfg_style == 2'd0);

  drw_ring_idx #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .len(cfg_len), .idx(idx)
  );

  drw_addr_gen #(.AW(WORD_W), .IDX_W(IDX_W), .HI_W(HI_W)) u_addr (
    .style(cfg_style), .base(cfg_base), .hi(cfg_hi), .idx(idx),
    .off(word_off(cfg_style, sel)), .addr(mem_addr)
  );

  // next-state
  always_comb begin
    st_d     = st_q;
    cap_stat = 1'b0;
    cap_aux  = 1'b0;
    cap_cmp  = 1'b0;
    adv      = 1'b0;
    clr      = 1'b0;
    unique case (st_q)
      ST_IDLE:    if (start) begin clr = 1'b1; st_d = ST_RD_STAT; end
      ST_RD_STAT: if (mem_gnt) begin
                    cap_stat = 1'b1;
                    st_d = mem_rdata[OWN_BIT] ? ST_RD_AUX : ST_HOLD;
                  end
      ST_HOLD:    if (poll) st_d = ST_RD_STAT;
      ST_RD_AUX:  if (mem_gnt) begin cap_aux = 1'b1; st_d = ST_OFFER; end
      ST_OFFER:   if (dsc_ready) st_d = ST_BUSY;
      ST_BUSY:    if (cmp_valid) begin cap_cmp = 1'b1; st_d = ST_WR_AUX; end
      ST_WR_AUX:  if (mem_gnt) st_d = ST_WR_STAT;
      ST_WR_STAT: if (mem_gnt) begin adv = 1'b1; st_d = ST_RD_STAT; end
      default:    st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stat_q <= '0;
      aux_q  <= '0;
      cflg_q <= '0;
      ccnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap_stat) stat_q <= mem_rdata;
      if (cap_aux)  aux_q  <= mem_rdata;
      if (cap_cmp) begin
        cflg_q <= cmp_flags;
        ccnt_q <= cmp_count;
      end
    end
  end

  // memory port
  always_comb begin
    mem_req = (st_q == ST_RD_STAT) || (st_q == ST_RD_AUX) ||
              (st_q == ST_WR_AUX)  || (st_q == ST_WR_STAT);
    mem_we  = (st_q == ST_WR_AUX) || (st_q == ST_WR_STAT);
    unique case (st_q)
      ST_RD_AUX: sel = ACC_AUX_RD;
      ST_WR_AUX: sel = ACC_AUX_WR;
      default:   sel = ACC_STAT;
    endcase
  end

  always_comb begin
    if (compact) begin
      aux_wr  = {ccnt_q, aux_q[FLD_W-1:0]};
      stat_wr = {1'b0, cflg_q[CFLG_W-1:0], stat_q[LO_W-1:0]};
    end else begin
      aux_wr  = {{(WORD_W-FLD_W){1'b0}}, ccnt_q};
      stat_wr = {1'b0, cflg_q, stat_q[FLD_W-1:0]};
    end
    if (st_q == ST_WR_STAT)     mem_wdata = stat_wr;
    else if (st_q == ST_WR_AUX) mem_wdata = aux_wr;
    else                        mem_wdata = '0;
  end

  // consumer side
  assign dsc_valid = (st_q == ST_OFFER);
  assign dsc_addr  = compact ? {cfg_hi, stat_q[LO_W-1:0]} : aux_q;
  assign dsc_len   = compact ? aux_q[FLD_W-1:0] : stat_q[FLD_W-1:0];
  assign dsc_flags = compact ? {{(FLG_W-CFLG_W){1'b0}}, stat_q[OWN_BIT-1 -: CFLG_W]}
                             : stat_q[OWN_BIT-1 -: FLG_W];

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R10
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R5
  no_write_unowned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> stat_q[OWN_BIT]);

  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(dsc_addr) && $stable(dsc_len)
                                   && $stable(dsc_flags)));

  // R7
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && mem_we && mem_gnt)) |-> !mem_wdata[OWN_BIT]);
endmodule

// File: tb/drw_desc_walker_test.sv
`timescale 1ns/1ps
module drw_desc_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_style = 2'd0;
  logic [31:0] cfg_base = 32'h0;
  logic [7:0]  cfg_hi = 8'h0;
  logic [15:0] cfg_len = 16'd1;
  logic        start = 1'b0, poll = 1'b0;
  logic        mem_req, mem_we, mem_gnt = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'h0;
  logic        dsc_valid, dsc_ready = 1'b0, cmp_valid = 1'b0;
  logic [31:0] dsc_addr;
  logic [15:0] dsc_len, cmp_count = 16'h0;
  logic [14:0] dsc_flags, cmp_flags = 15'h0;

  int n_chk = 0, n_err = 0;

  drw_desc_walker uut (
    .clk(clk), .rst_n(rst_n), .cfg_style(cfg_style), .cfg_base(cfg_base),
    .cfg_hi(cfg_hi), .cfg_len(cfg_len), .start(start), .poll(poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .dsc_valid(dsc_valid),
    .dsc_ready(dsc_ready), .dsc_addr(dsc_addr), .dsc_len(dsc_len),
    .dsc_flags(dsc_flags), .cmp_valid(cmp_valid), .cmp_flags(cmp_flags),
    .cmp_count(cmp_count)
  );

  always #2.5 clk = ~clk;

  // host memory model and access log
  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] lg_a [0:4095];
  logic [31:0] lg_d [0:4095];
  logic        lg_w [0:4095];
  int          lg_n = 0;

  always @(negedge clk) begin
    mem_gnt   = mem_req && ($urandom_range(0, 2) != 0);
    mem_rdata = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 32'h0;
  end

  always @(posedge clk) begin
    if (rst_n && mem_gnt && lg_n < 4096) begin
      lg_a[lg_n] = mem_addr;
      lg_w[lg_n] = mem_we;
      lg_d[lg_n] = mem_wdata;
      lg_n = lg_n + 1;
      if (mem_we) mem_m[mem_addr] = mem_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected entry layout
  logic [31:0] e_buf [0:7];
  logic [15:0] e_len [0:7];
  logic [14:0] e_flg [0:7];

  function automatic logic [3:0] offs(input int which); // 0 status, 1 read aux, 2 write aux
    if (cfg_style == 2'd0) return (which == 0) ? 4'd0 : 4'd4;
    if (cfg_style == 2'd1) return (which == 0) ? 4'd4 : ((which == 1) ? 4'd0 : 4'd8);
    return (which == 0) ? 4'd4 : ((which == 1) ? 4'd8 : 4'd0);
  endfunction

  function automatic logic [31:0] ea(input int idx, input int which);
    logic [31:0] s;
    if (cfg_style == 2'd0) begin
      s = (cfg_base & 32'hFFFF_FFF8) + 32'(idx) * 8 + 32'(offs(which));
      return {cfg_hi, s[23:0]};
    end
    s = (cfg_base & 32'hFFFF_FFF0) + 32'(idx) * 16 + 32'(offs(which));
    return s;
  endfunction

  task automatic put_entry(input int idx, input logic own);
    logic [31:0] b;
    b = $urandom;
    e_buf[idx] = b;
    e_len[idx] = 16'($urandom);
    e_flg[idx] = 15'($urandom);
    if (cfg_style == 2'd0) begin
      mem_m[ea(idx, 0)] = {own, e_flg[idx][6:0], b[23:0]};
      mem_m[ea(idx, 1)] = {16'h0, e_len[idx]};
    end else begin
      mem_m[ea(idx, 0)] = {own, e_flg[idx], e_len[idx]};
      mem_m[ea(idx, 1)] = b;
    end
  endtask

  task automatic wait_log(input int n);
    while (lg_n < n) @(negedge clk);
  endtask

  task automatic pulse_poll();
    @(negedge clk) poll = 1'b1;
    @(negedge clk) poll = 1'b0;
  endtask

  task automatic serve(input int idx, inout int lb);
    logic [14:0] cf;
    logic [15:0] cc;
    logic [31:0] xa;
    while (!dsc_valid) @(negedge clk);
    check("R1/R4 first access is status read", {31'h0, lg_w[lb]}, 32'h0);
    check("R2/R4/R10 status read address", lg_a[lb], ea(idx, 0));
    check("R4 second read direction", {31'h0, lg_w[lb+1]}, 32'h0);
    check("R2/R4/R10 second read address", lg_a[lb+1], ea(idx, 1));
    if (cfg_style == 2'd0) check("R3 high address byte", {24'h0, lg_a[lb][31:24]}, {24'h0, cfg_hi});
    xa = (cfg_style == 2'd0) ? {cfg_hi, e_buf[idx][23:0]} : e_buf[idx];
    check("R3/R6 offered buffer address", dsc_addr, xa);
    check("R6 offered length", {16'h0, dsc_len}, {16'h0, e_len[idx]});
    check("R6 offered flags", {17'h0, dsc_flags},
          (cfg_style == 2'd0) ? {25'h0, e_flg[idx][6:0]} : {17'h0, e_flg[idx]});
    repeat ($urandom_range(0, 3)) @(negedge clk);
    check("R6 offer still held", {31'h0, dsc_valid}, 32'h1);
    dsc_ready = 1'b1;
    @(negedge clk) dsc_ready = 1'b0;
    repeat ($urandom_range(0, 3)) @(negedge clk);
    check("R7 no write before completion", 32'(lg_n), 32'(lb + 2));
    cf = 15'($urandom);
    cc = 16'($urandom);
    cmp_flags = cf;
    cmp_count = cc;
    cmp_valid = 1'b1;
    @(negedge clk) cmp_valid = 1'b0;
    wait_log(lb + 4);
    check("R7 count word written first", {31'h0, lg_w[lb+2]}, 32'h1);
    check("R7 count word address", lg_a[lb+2], ea(idx, 2));
    check("R7 count word data", lg_d[lb+2],
          (cfg_style == 2'd0) ? {cc, e_len[idx]} : {16'h0, cc});
    check("R7 status written last", {31'h0, lg_w[lb+3]}, 32'h1);
    check("R7 status write address", lg_a[lb+3], ea(idx, 0));
    check("R7 status write data", lg_d[lb+3],
          (cfg_style == 2'd0) ? {1'b0, cf[6:0], e_buf[idx][23:0]}
                              : {1'b0, cf, e_len[idx]});
    lb = lb + 4;
  endtask

  task automatic run_ring(input logic [1:0] sty, input logic [31:0] base,
                          input logic [7:0] hi, input logic [15:0] len, input int nent);
    int lb;
    @(negedge clk) rst_n = 1'b0;
    cfg_style = sty;
    cfg_base  = base;
    cfg_hi    = hi;
    cfg_len   = len;
    for (int i = 0; i < 8; i++) if (len == 0 || i < int'(len)) put_entry(i, 1'b1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 no request after reset", {31'h0, mem_req}, 32'h0);
    check("R1 no offer after reset", {31'h0, dsc_valid}, 32'h0);
    lb = lg_n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < nent; k++) begin
      int idx;
      idx = (len == 0) ? k : k % int'(len);
      if (len != 0 && k >= int'(len)) begin
        // wrapped back onto a host-owned entry
        wait_log(lb + 1);
        check("R8 wrap reads entry status", lg_a[lb], ea(idx, 0));
        repeat (6) @(negedge clk);
        check("R5 no read-ahead while stalled", 32'(lg_n), 32'(lb + 1));
        check("R5 no offer while stalled", {31'h0, dsc_valid}, 32'h0);
        pulse_poll();
        wait_log(lb + 2);
        check("R5 poll re-reads same status", lg_a[lb+1], ea(idx, 0));
        check("R5 poll access is a read", {31'h0, lg_w[lb+1]}, 32'h0);
        repeat (6) @(negedge clk);
        check("R5 one read per poll", 32'(lg_n), 32'(lb + 2));
        put_entry(idx, 1'b1);
        pulse_poll();
        lb = lb + 2;
      end
      serve(idx, lb);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    // directed corners
    run_ring(2'd0, 32'h0000_1005, 8'hA5, 16'd3, 5);  // compact, unaligned base
    run_ring(2'd1, 32'h2000_010C, 8'h00, 16'd2, 4);  // wide
    run_ring(2'd2, 32'h3000_0208, 8'h11, 16'd1, 3);  // burst order, single entry ring
    run_ring(2'd3, 32'h4000_0FFF, 8'h22, 16'd2, 3);  // code 3 acts as burst order
    run_ring(2'd1, 32'h0000_0000, 8'h00, 16'hFFFF, 3); // long ring, no wrap
    run_ring(2'd0, 32'hFFFF_FFF0, 8'h3C, 16'd2, 3);  // compact near top of space
    // random rings
    for (int r = 0; r < 8; r++) begin
      logic [15:0] ln;
      ln = 16'($urandom_range(1, 5));
      run_ring(2'($urandom), $urandom, 8'($urandom), ln, int'(ln) + 2);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule